// File: doc/BRIEF.md
# Requester-Side SECDED Memory Bus Guard

This block sits between a requester and a memory bus and protects every access end to end. On a write, the 32-bit data word is turned into a 39-bit SECDED codeword in the same cycle and driven onto the bus. The bus also carries an even-parity tag over the address and the write flag. The memory keeps the codeword and the tag unchanged. On a read, the codeword and tag that come back are checked only once they reach the requester. This means a fault injected on the bus is caught as surely as a fault in the storage cells.

Single-bit faults are corrected without stalling the requester. Double-bit faults are flagged and never corrected, and their address is captured. A returned tag that does not match the issued read address is reported on its own flag. A saturating counter records every corrected event. A small register port sets a threshold, and crossing that threshold raises an early-warning alert.

A two-state controller keeps one read outstanding at a time:
- `ST_IDLE` accepts any request. A read moves it to `ST_RD_WAIT` (transition *issue_read*); a write stays in `ST_IDLE` (transition *post_write*).
- `ST_RD_WAIT` holds the request port closed until the memory answers, then returns to `ST_IDLE` (transition *take_response*).

Top module: `bus_ecc_guard`

## Requirements
- R1: A write accepted in ST_IDLE appears on the memory side in the same cycle. Its codeword carries the data unchanged in bits 31:0, six Hamming check bits in bits 37:32 and an overall parity bit in bit 38. Bit 38 makes the XOR of all 39 bits zero.
- R2: On every memory request, the XOR of the address bits, the write flag and the outgoing tag is zero.
- R3: The read response is valid in the same cycle as the memory's return strobe. A clean codeword gives back the stored data with all three error flags low. A response is never valid two cycles in a row.
- R4: A codeword with exactly one flipped bit, in any of the 39 positions, returns the original data with the corrected flag high and the uncorrectable flag low.
- R5: A codeword with exactly two flipped bits raises the uncorrectable flag with the corrected flag low. It captures the read address in register 3 and sets sticky status bit 1.
- R6: The returned tag is compared with the XOR of the issued read address and a 1 (the write flag the location was stored with). A mismatch raises the address/control flag and sets sticky status bit 2, without touching the data flags or the data.
- R7: Each corrected response adds one to the event counter (register 1), visible from the next cycle. The counter holds at 2^CNT_W-1.
- R8: Any write to register 1 clears the counter. The clear wins over an increment in the same cycle.
- R9: The alert output and status bit 0 are high while the threshold (register 0) is non-zero and the counter is at or above it. A zero threshold keeps the alert low.
- R10: After reset the block is in ST_IDLE with the request port ready. From a read issue until the response, the request port is not ready.
- R11: Register 0 reads back the value written to its low CNT_W bits. Writing a 1 to status bit 1 or bit 2 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester access strobe |
| req_ready | output | 1 | Request port open (ST_IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Corrected read data |
| rsp_sbe | output | 1 | Single-bit error corrected |
| rsp_dbe | output | 1 | Uncorrectable error |
| rsp_aerr | output | 1 | Address/control tag mismatch |
| mem_valid | output | 1 | Memory request strobe |
| mem_write | output | 1 | Memory write flag |
| mem_addr | output | ADDR_W | Memory address |
| mem_wcode | output | 39 | Encoded write codeword |
| mem_wtag | output | 1 | Address/control parity tag |
| mem_rvalid | input | 1 | Memory read return strobe |
| mem_rcode | input | 39 | Returned codeword |
| mem_rtag | input | 1 | Returned tag |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 threshold, 1 counter, 2 status, 3 captured address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| err_alert | output | 1 | Threshold alert |

## Verification
The codeword, the tag and the request strobe are due in the same cycle as the request. The bench samples them after driving inputs on the falling edge and before the next rising edge. Read results are due in the cycle in which the memory model raises its return strobe, one edge after issue, so they are sampled just after the falling edge that follows. The counter, alert, status and captured address change at the edge that ends the response cycle. The bench reads them only at a falling edge after that edge.

// File: rtl/bus_ecc_pkg.sv
package bus_ecc_pkg;

    localparam int DATA_W   = 32;
    localparam int HAM_W    = 6;
    localparam int CODE_W   = DATA_W + HAM_W + 1;
    localparam int LAST_POS = DATA_W + HAM_W;
    localparam int REG_W    = 32;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_RD_WAIT = 1'b1
    } guard_state_e;

    typedef enum logic [1:0] {
        RG_THRESH   = 2'd0,
        RG_COUNT    = 2'd1,
        RG_STATUS   = 2'd2,
        RG_DBE_ADDR = 2'd3
    } reg_sel_e;

    // True for zero and for powers of two (check-bit slots of the layout).
    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Hamming position (1..LAST_POS) of data bit i; data fills the non-power slots.
    function automatic logic [HAM_W-1:0] pos_of(input int i);
        int cnt;
        logic [HAM_W-1:0] r;
        cnt = 0;
        r   = '0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == i) r = p[HAM_W-1:0];
                cnt++;
            end
        end
        return r;
    endfunction

    // Check bits: XOR of the positions of all set data bits.
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) acc = acc ^ pos_of(i);
        end
        return acc;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import bus_ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [HAM_W-1:0] ham;
    logic             total;

    always_comb begin
        ham    = ham_bits(data_i);
        total  = ^{ham, data_i};
        code_o = {total, ham, data_i};
    end

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
    import bus_ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sbe_o,
    output logic              dbe_o
);

    logic [DATA_W-1:0] rx_data;
    logic [HAM_W-1:0]  rx_ham;
    logic [HAM_W-1:0]  syn;
    logic              odd;
    logic              hit;
    logic              side_bit;

    always_comb begin
        rx_data  = code_i[DATA_W-1:0];
        rx_ham   = code_i[DATA_W +: HAM_W];
        syn      = ham_bits(rx_data) ^ rx_ham;
        odd      = ^code_i;
        side_bit = is_pow2(int'(syn));
        hit      = 1'b0;
        data_o   = rx_data;
        for (int i = 0; i < DATA_W; i++) begin
            if (odd && (syn == pos_of(i))) begin
                data_o[i] = ~rx_data[i];
                hit       = 1'b1;
            end
        end
        sbe_o = odd && (hit || side_bit);
        dbe_o = (!odd && (syn != '0)) || (odd && !hit && !side_bit);
    end

endmodule

// File: rtl/ecc_event_log.sv
module ecc_event_log
    import bus_ecc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_sbe,
    input  logic              evt_dbe,
    input  logic              evt_aerr,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              cfg_we,
    input  reg_sel_e          cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              alert_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]  thr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dbe_seen_q;
    logic              aerr_seen_q;
    logic [ADDR_W-1:0] dbe_addr_q;
    logic              wr_thr, wr_cnt, wr_sts;

    assign wr_thr = cfg_we && (cfg_sel == RG_THRESH);
    assign wr_cnt = cfg_we && (cfg_sel == RG_COUNT);
    assign wr_sts = cfg_we && (cfg_sel == RG_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (wr_thr) begin
            thr_q <= cfg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= '0;
        end else if (evt_sbe && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbe_seen_q  <= 1'b0;
            aerr_seen_q <= 1'b0;
            dbe_addr_q  <= '0;
        end else begin
            if (evt_dbe) begin
                dbe_seen_q <= 1'b1;
                dbe_addr_q <= evt_addr;
            end else if (wr_sts && cfg_wdata[1]) begin
                dbe_seen_q <= 1'b0;
            end
            if (evt_aerr) begin
                aerr_seen_q <= 1'b1;
            end else if (wr_sts && cfg_wdata[2]) begin
                aerr_seen_q <= 1'b0;
            end
        end
    end

    assign alert_o = (thr_q != '0) && (cnt_q >= thr_q);
    assign count_o = cnt_q;

    always_comb begin
        unique case (cfg_sel)
            RG_THRESH:   cfg_rdata = REG_W'(thr_q);
            RG_COUNT:    cfg_rdata = REG_W'(cnt_q);
            RG_STATUS:   cfg_rdata = REG_W'({aerr_seen_q, dbe_seen_q, alert_o});
            RG_DBE_ADDR: cfg_rdata = REG_W'(dbe_addr_q);
            default:     cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bus_ecc_guard.sv
module bus_ecc_guard
    import bus_ecc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_sbe,
    output logic              rsp_dbe,
    output logic              rsp_aerr,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [38:0]       mem_wcode,
    output logic              mem_wtag,
    input  logic              mem_rvalid,
    input  logic [38:0]       mem_rcode,
    input  logic              mem_rtag,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              err_alert
);

    guard_state_e      state_q, state_d;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] fix_data;
    logic              fix_sbe, fix_dbe;
    logic              tag_expect;
    logic [CNT_W-1:0]  sbe_count;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: issue_read, post_write, take_response
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid && !req_write) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rvalid)              state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_valid = req_valid;
            end
            ST_RD_WAIT: begin
                rsp_valid = mem_rvalid;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                             rd_addr_q <= '0;
        else if (state_q == ST_IDLE && req_valid && !req_write) rd_addr_q <= req_addr;
    end

    assign mem_write = req_write;
    assign mem_addr  = req_addr;
    assign mem_wtag  = ^{req_addr, req_write};

    ecc_encoder u_enc (
        .data_i (req_wdata),
        .code_o (mem_wcode)
    );

    ecc_corrector u_fix (
        .code_i (mem_rcode),
        .data_o (fix_data),
        .sbe_o  (fix_sbe),
        .dbe_o  (fix_dbe)
    );

    assign tag_expect = ^{rd_addr_q, 1'b1};
    assign rsp_rdata  = fix_data;
    assign rsp_sbe    = rsp_valid && fix_sbe;
    assign rsp_dbe    = rsp_valid && fix_dbe;
    assign rsp_aerr   = rsp_valid && (mem_rtag != tag_expect);

    ecc_event_log #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_sbe   (rsp_sbe),
        .evt_dbe   (rsp_dbe),
        .evt_aerr  (rsp_aerr),
        .evt_addr  (rd_addr_q),
        .cfg_we    (cfg_we),
        .cfg_sel   (reg_sel_e'(cfg_sel)),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .alert_o   (err_alert),
        .count_o   (sbe_count)
    );

endmodule

// File: rtl/bus_ecc_guard_props.sv
module bus_ecc_guard_props #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [31:0]       req_wdata,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [38:0]       mem_wcode,
    input logic              mem_wtag,
    input logic              rsp_valid,
    input logic              rsp_sbe,
    input logic              rsp_dbe,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic [CNT_W-1:0]  sbe_count
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    logic clr;
    assign clr = cfg_we && (cfg_sel == 2'd1);

    p_wcode_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_wcode[31:0] == req_wdata);

    p_code_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> (^mem_wcode) == 1'b0);

    p_tag_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (^{mem_addr, mem_write, mem_wtag}) == 1'b0);

    p_single_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_sbe && rsp_dbe));

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sbe && !clr && (sbe_count != CMAX) |=> sbe_count == $past(sbe_count) + CNT_W'(1));

    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_count == CMAX) && !clr |=> sbe_count == CMAX);

    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> sbe_count == '0);

    p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_write |=> !req_ready);

endmodule

bind bus_ecc_guard bus_ecc_guard_props #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_wdata (req_wdata),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wcode (mem_wcode),
    .mem_wtag  (mem_wtag),
    .rsp_valid (rsp_valid),
    .rsp_sbe   (rsp_sbe),
    .rsp_dbe   (rsp_dbe),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .sbe_count (sbe_count)
);

// File: tb/bus_ecc_guard_bench.sv
module bus_ecc_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int CW         = 4;
    localparam int CMAX       = (1 << CW) - 1;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_sbe, rsp_dbe, rsp_aerr;
    logic [31:0]   rsp_rdata;
    logic          mem_valid, mem_write, mem_wtag;
    logic [AW-1:0] mem_addr;
    logic [38:0]   mem_wcode;
    logic          mem_rvalid = 1'b0;
    logic [38:0]   mem_rcode = '0;
    logic          mem_rtag = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          err_alert;

    logic [38:0]   ram_code [DEPTH];
    logic          ram_tag  [DEPTH];
    logic [38:0]   inj_mask = '0;
    logic          inj_tag  = 1'b0;
    logic [31:0]   shadow   [DEPTH];

    int n_chk = 0;
    int n_err = 0;
    int model_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_ecc_guard #(.ADDR_W(AW), .CNT_W(CW)) u_bus_ecc_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sbe(rsp_sbe),
        .rsp_dbe(rsp_dbe), .rsp_aerr(rsp_aerr),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wcode(mem_wcode), .mem_wtag(mem_wtag),
        .mem_rvalid(mem_rvalid), .mem_rcode(mem_rcode), .mem_rtag(mem_rtag),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .err_alert(err_alert)
    );

    // Behavioural memory: answers a read one edge after issue.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_valid && mem_write) begin
                ram_code[mem_addr] <= mem_wcode;
                ram_tag[mem_addr]  <= mem_wtag;
            end
            if (mem_valid && !mem_write) begin
                mem_rvalid <= 1'b1;
                mem_rcode  <= ram_code[mem_addr] ^ inj_mask;
                mem_rtag   <= ram_tag[mem_addr] ^ inj_tag;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [38:0] flip_mask(input int nflip);
        logic [38:0] m;
        int b1, b2;
        m  = '0;
        b1 = $urandom_range(0, 38);
        b2 = (b1 + 1 + $urandom_range(0, 37)) % 39;
        if (nflip >= 1) m[b1] = 1'b1;
        if (nflip >= 2) m[b2] = 1'b1;
        return m;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #1;
        chk("R1 mem_valid same cycle", 64'(mem_valid), 64'd1);
        chk("R1 data bits", 64'(mem_wcode[31:0]), 64'(d));
        chk("R1 even codeword", 64'(^mem_wcode), 64'd0);
        chk("R2 tag parity", 64'(^{mem_addr, mem_write, mem_wtag}), 64'd0);
        shadow[a] = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // nflip: 0 clean, 1 single, 2 double (or explicit mask when mask != 0)
    task automatic do_read(input logic [AW-1:0] a, input logic [38:0] mask,
                           input int nflip, input logic tflip);
        @(negedge clk);
        inj_mask = mask; inj_tag = tflip;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        chk("R2 read tag parity", 64'(^{mem_addr, mem_write, mem_wtag}), 64'd0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R10 ready low while waiting", 64'(req_ready), 64'd0);
        chk("R3 response same cycle", 64'(rsp_valid), 64'd1);
        chk("R6 address/control flag", 64'(rsp_aerr), 64'(tflip));
        if (nflip == 0) begin
            chk("R3 clean data", 64'(rsp_rdata), 64'(shadow[a]));
            chk("R3 no sbe", 64'(rsp_sbe), 64'd0);
            chk("R3 no dbe", 64'(rsp_dbe), 64'd0);
        end else if (nflip == 1) begin
            chk("R4 corrected data", 64'(rsp_rdata), 64'(shadow[a]));
            chk("R4 sbe", 64'(rsp_sbe), 64'd1);
            chk("R4 no dbe", 64'(rsp_dbe), 64'd0);
            if (model_cnt < CMAX) model_cnt++;
        end else begin
            chk("R5 dbe", 64'(rsp_dbe), 64'd1);
            chk("R5 no sbe", 64'(rsp_sbe), 64'd0);
        end
        @(posedge clk);
        inj_mask = '0; inj_tag = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 ready after reset", 64'(req_ready), 64'd1);
        chk("R3 no response after reset", 64'(rsp_valid), 64'd0);
        chk("R9 alert low after reset", 64'(err_alert), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_read(2'd1, rd); chk("R7 counter reset", 64'(rd), 64'd0);
        cfg_read(2'd2, rd); chk("R11 status reset", 64'(rd), 64'd0);

        cfg_write(2'd0, 32'd5);
        cfg_read(2'd0, rd); chk("R11 threshold readback", 64'(rd), 64'd5);

        // Directed single-bit cases: data bit, check bit, overall bit
        do_write(4'd3, 32'hA5A5_1234);
        do_read(4'd3, '0, 0, 1'b0);
        do_read(4'd3, 39'd1 << 0, 1, 1'b0);
        do_read(4'd3, 39'd1 << 31, 1, 1'b0);
        do_read(4'd3, 39'd1 << 33, 1, 1'b0);
        do_read(4'd3, 39'd1 << 38, 1, 1'b0);
        cfg_read(2'd1, rd); chk("R7 count after four", 64'(rd), 64'(model_cnt));
        chk("R9 below threshold", 64'(err_alert), 64'd0);
        do_read(4'd3, 39'd1 << 37, 1, 1'b0);
        cfg_read(2'd1, rd); chk("R7 count at five", 64'(rd), 64'd5);
        chk("R9 alert at threshold", 64'(err_alert), 64'd1);
        cfg_read(2'd2, rd); chk("R9 status alert bit", 64'(rd[0]), 64'd1);

        // Double-bit error and capture
        do_write(4'd9, 32'h0F0F_C3C3);
        do_read(4'd9, (39'd1 << 5) | (39'd1 << 20), 2, 1'b0);
        cfg_read(2'd3, rd); chk("R5 captured address", 64'(rd), 64'd9);
        cfg_read(2'd2, rd); chk("R5 sticky dbe", 64'(rd[1]), 64'd1);
        cfg_write(2'd2, 32'h2);
        cfg_read(2'd2, rd); chk("R11 dbe cleared", 64'(rd[1]), 64'd0);
        do_read(4'd9, (39'd1 << 32) | (39'd1 << 38), 2, 1'b0);

        // Address/control tag fault, data intact
        do_read(4'd3, '0, 0, 1'b1);
        cfg_read(2'd2, rd); chk("R6 sticky tag error", 64'(rd[2]), 64'd1);
        cfg_write(2'd2, 32'h4);
        cfg_read(2'd2, rd); chk("R11 tag error cleared", 64'(rd[2]), 64'd0);

        // Counter clear
        cfg_write(2'd1, 32'h0);
        model_cnt = 0;
        cfg_read(2'd1, rd); chk("R8 counter cleared", 64'(rd), 64'd0);
        chk("R9 alert drops after clear", 64'(err_alert), 64'd0);

        // Zero threshold disables the alert, and saturation
        cfg_write(2'd0, 32'd0);
        for (int k = 0; k < CMAX + 4; k++) do_read(4'd3, flip_mask(1), 1, 1'b0);
        cfg_read(2'd1, rd); chk("R7 saturated count", 64'(rd), 64'(CMAX));
        chk("R9 zero threshold keeps alert low", 64'(err_alert), 64'd0);
        cfg_write(2'd0, 32'd3);
        chk("R9 alert with saturated count", 64'(err_alert), 64'd1);

        // Randomised traffic
        cfg_write(2'd1, 32'h0);
        model_cnt = 0;
        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), $urandom());
        for (int it = 0; it < 150; it++) begin
            logic [AW-1:0] ra;
            int nf;
            ra = AW'($urandom_range(0, DEPTH - 1));
            if ($urandom_range(0, 3) == 0) begin
                do_write(ra, $urandom());
            end else begin
                nf = $urandom_range(0, 2);
                do_read(ra, flip_mask(nf), nf, ($urandom_range(0, 7) == 0));
            end
        end
        cfg_read(2'd1, rd); chk("R7 random count", 64'(rd), 64'(model_cnt));
        chk("R9 random alert", 64'(err_alert), 64'(model_cnt >= 3));
        finish_run();
    end

endmodule